// File: doc/BRIEF.md
# Two-Pole Error-Feedback Noise Shaper

This block turns a 20-bit signed audio stream, delivered at sixteen times the audio sample rate, into a stream of 5-bit codes for a multi-level current DAC. Each incoming sample is held and stepped through the shaping loop several times, which raises the rate to the full oversampled rate. Each step yields one code. The repeat count follows the system-clock ratio and the speed mode. With a 256x clock the repeat count is 8 in normal speed and 4 in double speed. With a 384x clock it is 6 in normal speed and 3 in double speed. Only one audio channel is handled, so a stereo path uses two copies of the block.

The loop keeps the coarse quantiser's error at full precision and feeds it back with a second-order weighting. The quantisation noise is therefore pushed out of the audio band, and the mean of the code stream tracks the input exactly. The loop state is the two most recent errors.

Both data sides use valid/ready handshakes. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low until every repeat of the held sample has been sent. A code leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending code and the whole loop are frozen, so back-pressure loses no step and repeats no step. The two mode pins are plain levels and are read only at the moment a sample is accepted.

Top module: `ns2_shaper`

## Requirements
- R1: A synchronous reset clears both stored errors, drives `out_code` to the midpoint 16 with `out_valid` low and `in_ready` high, and the first shaped codes after reset equal those of a fresh loop.
- R2: An accepted sample produces exactly as many output codes as the repeat count: 8 for `cfg_clk384`=0,`cfg_dbl`=0, 6 for 1,0, 4 for 0,1 and 3 for 1,1. `in_ready` returns high only after the last of these codes has been produced.
- R3: Each step forms v = x + 2*e1 - e2 and takes q = floor(v / 2^15), clamped to -16..15. It outputs the code q + 16 (offset binary, 0..31) and stores the new error e = v - q*2^15, where e1 is the previous error and e2 the one before it.
- R4: A stored error outside the signed 20-bit range is clipped to -524288 or 524287 and never wraps. A full-scale positive input then keeps producing code 31, and a full-scale negative input keeps producing code 0.
- R5: An input that is an exact multiple of 2^15 produces the constant code x/2^15 + 16 on every step. In particular, 0 gives 16, 98304 gives 19 and -524288 gives 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_code` does not change and the loop does not advance.
- R7: `in_valid` has no effect while `in_ready` is low: the held sample is not replaced, and no extra codes appear.
- R8: Changes on `cfg_clk384` or `cfg_dbl` after a sample has been accepted do not change that sample's repeat count.
- R9: The input 16384 (half a code step), taken from a cleared loop, gives the repeating code pattern 16, 17, 17, 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_clk384 | input | 1 | 1 selects the 384x clock ratio (repeat 6), 0 selects 256x (repeat 8) |
| cfg_dbl | input | 1 | 1 selects double speed, which halves the repeat count |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a new sample |
| in_data | input | 20 | Signed two's-complement input sample |
| out_valid | output | 1 | `out_code` holds a new code |
| out_ready | input | 1 | Downstream accepts the code |
| out_code | output | 5 | Offset-binary DAC code, 16 = zero |

## Verification
The loop is driven with zero and exact code multiples, where any stray error feedback shows up as a non-constant code. It is also driven with a half-step input, whose fixed four-code pattern shows whether the second-order weighting and the floor rounding are right. Full-scale positive and negative inputs test the saturation and the error clipping, as opposed to wraparound. Arbitrary mid-range values in all four modes are compared step by step against a reference model, which also checks the repeat count of each mode. Stalled output, ignored input requests and mid-stream reset separate correct handshake and state behaviour from steps that are dropped or duplicated.

// File: rtl/ns2_pkg.sv
package ns2_pkg;

  // Repeat count for one held sample: the base ratio picked by the clock
  // selection, halved in double-speed operation.
  function automatic int reps_for(input int r256, input int r384,
                                  input logic clk384, input logic dbl);
    int base;
    base = clk384 ? r384 : r256;
    return dbl ? (base / 2) : base;
  endfunction

endpackage

// File: rtl/ns2_hold.sv
// Sample-and-hold stage: captures one input sample and counts the loop
// steps still owed to it.
module ns2_hold #(
  parameter int DW   = 20,
  parameter int R256 = 8,
  parameter int R384 = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_clk384,
  input  logic                 cfg_dbl,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic                 step,
  output logic                 busy,
  output logic signed [DW-1:0] hold_x
);
  localparam int MAXR = (R256 > R384) ? R256 : R384;
  localparam int CNTW = $clog2(MAXR + 1);

  logic [CNTW-1:0] left;
  logic            take;

  assign in_ready = (left == '0);
  assign busy     = !in_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      hold_x <= '0;
    end else if (take) begin
      left   <= CNTW'(ns2_pkg::reps_for(R256, R384, cfg_clk384, cfg_dbl));
      hold_x <= in_data;
    end else if (step) begin
      left   <= left - 1'b1;
    end
  end

  // R7: a refused request must leave the held sample alone
  assert_hold_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> $stable(hold_x));

  // R2: the step counter never exceeds the largest repeat count
  assert_left_range_R2: assert property (@(posedge clk) disable iff (rst)
    left <= CNTW'(MAXR));

  // R2: an accepted sample always owes at least one step
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/ns2_quant.sv
// Coarse quantiser: floor to the top CW bits, saturate, and return the
// residual error clipped to the input width.
module ns2_quant #(
  parameter int DW = 20,
  parameter int CW = 5
) (
  input  logic signed [DW+2:0] v,
  output logic        [CW-1:0] code,
  output logic signed [DW-1:0] err
);
  localparam int FRAC = DW - CW;
  localparam int VW   = DW + 3;
  localparam int QW   = VW - FRAC;

  localparam logic signed [QW-1:0] Q_HI = QW'((1 << (CW - 1)) - 1);
  localparam logic signed [QW-1:0] Q_LO = QW'(-(1 << (CW - 1)));
  localparam logic signed [VW-1:0] E_HI = VW'((longint'(1) << (DW - 1)) - 1);
  localparam logic signed [VW-1:0] E_LO = VW'(-(longint'(1) << (DW - 1)));

  logic signed [QW-1:0] q_raw;
  logic signed [QW-1:0] q_sat;
  logic signed [VW-1:0] q_scaled;
  logic signed [VW-1:0] e_full;

  always_comb begin
    q_raw = $signed(v[VW-1:FRAC]);
    if (q_raw > Q_HI)      q_sat = Q_HI;
    else if (q_raw < Q_LO) q_sat = Q_LO;
    else                   q_sat = q_raw;
  end

  // Offset binary: flip the sign bit of the clamped two's-complement value.
  assign code     = {~q_sat[CW-1], q_sat[CW-2:0]};
  assign q_scaled = $signed({q_sat, {FRAC{1'b0}}});
  assign e_full   = v - q_scaled;

  always_comb begin
    if (e_full > E_HI)      err = E_HI[DW-1:0];
    else if (e_full < E_LO) err = E_LO[DW-1:0];
    else                    err = e_full[DW-1:0];
  end

endmodule

// File: rtl/ns2_loop.sv
// Second-order error-feedback loop with a registered output slot.
module ns2_loop #(
  parameter int DW = 20,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busy,
  input  logic signed [DW-1:0] hold_x,
  input  logic                 out_ready,
  output logic                 step,
  output logic                 out_valid,
  output logic        [CW-1:0] out_code
);
  localparam int FRAC = DW - CW;
  localparam int VW   = DW + 3;
  localparam logic [CW-1:0]        MIDCODE = {1'b1, {(CW-1){1'b0}}};
  localparam logic signed [VW-1:0] V_TOP   = VW'(longint'(1) << (DW - 1));
  localparam logic signed [VW-1:0] V_BOT   = VW'(-(longint'(1) << (DW - 1)));
  localparam logic signed [VW-1:0] V_ECLIP =
    VW'((longint'(1) << DW) - 1 - (longint'(1) << FRAC));
  localparam logic signed [DW-1:0] ERRMAX  = DW'((longint'(1) << (DW - 1)) - 1);

  logic signed [DW-1:0] e1;
  logic signed [DW-1:0] e2;
  logic signed [VW-1:0] v;
  logic        [CW-1:0] q_code;
  logic signed [DW-1:0] q_err;

  // Feedback sum: x + 2*e[n-1] - e[n-2], wide enough for every input.
  assign v    = VW'(hold_x) + (VW'(e1) <<< 1) - VW'(e2);
  assign step = busy && (!out_valid || out_ready);

  ns2_quant #(.DW(DW), .CW(CW)) u_quant (
    .v    (v),
    .code (q_code),
    .err  (q_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      e1        <= '0;
      e2        <= '0;
      out_valid <= 1'b0;
      out_code  <= MIDCODE;
    end else if (step) begin
      out_code  <= q_code;
      out_valid <= 1'b1;
      e2        <= e1;
      e1        <= q_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: stalled output holds its code
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  // R1: first cycle after reset shows midpoint, nothing valid
  assert_reset_mid_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_code == MIDCODE && !out_valid));

  // R3: sums at or above full scale give the top code
  assert_sat_top_R3: assert property (@(posedge clk) disable iff (rst)
    (step && v >= V_TOP) |=> (out_code == '1));

  // R3: sums below negative full scale give the bottom code
  assert_sat_bot_R3: assert property (@(posedge clk) disable iff (rst)
    (step && v < V_BOT) |=> (out_code == '0));

  // R4: an oversize residual is clipped, not wrapped
  assert_err_clip_R4: assert property (@(posedge clk) disable iff (rst)
    (step && v > V_ECLIP) |=> (e1 == ERRMAX));

endmodule

// File: rtl/ns2_shaper.sv
// Top: sample-and-hold feeding the second-order shaping loop.
module ns2_shaper #(
  parameter int DW   = 20,
  parameter int CW   = 5,
  parameter int R256 = 8,
  parameter int R384 = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_clk384,
  input  logic          cfg_dbl,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_code
);
  logic                 busy;
  logic                 step;
  logic signed [DW-1:0] hold_x;

  ns2_hold #(.DW(DW), .R256(R256), .R384(R384)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .cfg_clk384 (cfg_clk384),
    .cfg_dbl    (cfg_dbl),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    ($signed(in_data)),
    .step       (step),
    .busy       (busy),
    .hold_x     (hold_x)
  );

  ns2_loop #(.DW(DW), .CW(CW)) u_loop (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .hold_x    (hold_x),
    .out_ready (out_ready),
    .step      (step),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  // R2: a code is only ever produced for a held sample
  assert_valid_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && in_ready) |=> !out_valid);

endmodule

// File: tb/ns2_shaper_bench.sv
module ns2_shaper_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_clk384 = 1'b0;
  logic        cfg_dbl = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_code;

  always #2.5 clk = ~clk;

  ns2_shaper u_ns2_shaper (
    .clk        (clk),
    .rst        (rst),
    .cfg_clk384 (cfg_clk384),
    .cfg_dbl    (cfg_dbl),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_code   (out_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int xfer_total = 0;
  logic [4:0] rx_code [256];
  longint me1 = 0;
  longint me2 = 0;

  // {repeat count, clk384, dbl, sample}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {4'd8, 1'b0, 1'b0, 20'(0)},
    {4'd8, 1'b0, 1'b0, 20'(16384)},
    {4'd6, 1'b1, 1'b0, 20'(98304)},
    {4'd4, 1'b0, 1'b1, 20'(-50000)},
    {4'd3, 1'b1, 1'b1, 20'(123457)},
    {4'd8, 1'b0, 1'b0, 20'(524287)},
    {4'd8, 1'b0, 1'b0, 20'(524287)},
    {4'd6, 1'b1, 1'b0, 20'(-524288)},
    {4'd4, 1'b0, 1'b1, 20'(0)},
    {4'd8, 1'b0, 1'b0, 20'(-1)},
    {4'd3, 1'b1, 1'b1, 20'(300000)},
    {4'd6, 1'b1, 1'b0, 20'(-200000)}
  };

  // Output monitor: records every completed code transfer.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      rx_code[8'(xfer_total)] = out_code;
      xfer_total = xfer_total + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference loop from the requirement formula (R3, R4).
  task automatic model(input longint x, output int code);
    longint v, q, e;
    v = x + 2 * me1 - me2;
    q = v >>> 15;
    if (q > 15) q = 15;
    if (q < -16) q = -16;
    e = v - q * 32768;
    if (e > 524287) e = 524287;
    if (e < -524288) e = -524288;
    me2 = me1;
    me1 = e;
    code = int'(q) + 16;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    me1 = 0;
    me2 = 0;
  endtask

  task automatic send(input logic [19:0] x, input bit c384, input bit dbl);
    bit acc;
    @(posedge clk); #1;
    in_data = x;
    cfg_clk384 = c384;
    cfg_dbl = dbl;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(in_ready && !out_valid));
  endtask

  task automatic run_vec(input logic [19:0] x, input bit c384, input bit dbl,
                         input int reps, input string tag, input bit flip);
    int base, got, c;
    base = xfer_total;
    send(x, c384, dbl);
    if (flip) begin
      cfg_clk384 = ~c384;
      cfg_dbl = ~dbl;
    end
    wait_idle();
    got = xfer_total - base;
    chk(got == reps, flip ? "R8 count" : "R2 count", got, reps);
    for (int i = 0; i < reps; i++) begin
      model(longint'($signed(x)), c);
      if (i < got) chk(int'(rx_code[8'(base + i)]) == c, tag,
                       int'(rx_code[8'(base + i)]), c);
    end
  endtask

  initial begin
    #250000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base, c;
    logic [4:0] held;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(int'(out_code) == 16, "R1 code", int'(out_code), 16);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

    // Table walk: shaping (R3), repeat counts (R2), clipping (R4)
    for (int k = 0; k < NV; k++) begin
      run_vec(VEC[k][19:0], VEC[k][21], VEC[k][20], int'(VEC[k][25:22]),
              "R3/R4 code", 1'b0);
    end

    // R1 + R9: mid-stream reset, then half-step pattern from a clean loop
    do_reset();
    @(negedge clk);
    chk(int'(out_code) == 16, "R1 code after reset", int'(out_code), 16);
    base = xfer_total;
    run_vec(20'(16384), 1'b0, 1'b0, 8, "R9 model", 1'b0);
    for (int i = 0; i < 8; i++) begin
      c = ((i % 4) == 1 || (i % 4) == 2) ? 17 : 16;
      chk(int'(rx_code[8'(base + i)]) == c, "R9 pattern",
          int'(rx_code[8'(base + i)]), c);
    end

    // R5: exact multiples give constant codes
    do_reset();
    base = xfer_total;
    run_vec(20'(98304), 1'b0, 1'b0, 8, "R5 model", 1'b0);
    for (int i = 0; i < 8; i++)
      chk(int'(rx_code[8'(base + i)]) == 19, "R5 const 19",
          int'(rx_code[8'(base + i)]), 19);
    base = xfer_total;
    run_vec(20'(0), 1'b1, 1'b0, 6, "R5 model", 1'b0);
    for (int i = 0; i < 6; i++)
      chk(int'(rx_code[8'(base + i)]) == 16, "R5 const 16",
          int'(rx_code[8'(base + i)]), 16);

    // R4: full-scale positive stays at top code for many samples
    do_reset();
    for (int k = 0; k < 3; k++) begin
      base = xfer_total;
      run_vec(20'(524287), 1'b0, 1'b0, 8, "R4 model", 1'b0);
      for (int i = 0; i < 8; i++)
        chk(int'(rx_code[8'(base + i)]) == 31, "R4 top",
            int'(rx_code[8'(base + i)]), 31);
    end

    // R8: mode pins flipped after acceptance
    do_reset();
    run_vec(20'(-70000), 1'b0, 1'b0, 8, "R8 code", 1'b1);
    run_vec(20'(45000), 1'b1, 1'b1, 3, "R8 code", 1'b1);

    // R6 + R7: stall the output and push refused requests
    do_reset();
    base = xfer_total;
    send(20'(200000), 1'b0, 1'b0);
    out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid", int'(out_valid), 1);
    held = out_code;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data = 20'(-300000);
      @(negedge clk);
      chk(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
      chk(out_code == held, "R6 code held", int'(out_code), int'(held));
      chk(in_ready == 1'b0, "R7 ready low", int'(in_ready), 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    wait_idle();
    chk(xfer_total - base == 8, "R6 count", xfer_total - base, 8);
    for (int i = 0; i < 8; i++) begin
      model(longint'(200000), c);
      chk(int'(rx_code[8'(base + i)]) == c, "R7 held sample",
          int'(rx_code[8'(base + i)]), c);
    end
    repeat (3) @(negedge clk);
    chk(xfer_total - base == 8, "R7 no extra", xfer_total - base, 8);
    chk(in_ready == 1'b1, "R7 idle", int'(in_ready), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule